// File: doc/BRIEF.md
# SPI FIFO Level Interrupt Controller

This block gathers the fill-level conditions of a SPI controller's receive and transmit FIFOs, together with a handful of error events, into a single 13-bit interrupt status register. It then gates that register with an enable mask and drives one interrupt line towards the processor. The FIFOs and the serial engine sit outside; this block only sees their occupancy counts, their full and empty flags, a pulse for each received data word, and a vector of external event pulses.

The status register holds two kinds of bit. Level bits are rebuilt from the live FIFO state on every clock and cannot be cleared by software. Event bits latch on their trigger and stay set until software writes a one to them. The enable mask is never written directly: one address sets mask bits and another clears them, so that several agents can change different bits without a read-modify-write race. Two programmable thresholds, one per direction, decide when the receive side counts as "enough data" and the transmit side as "room available".

The interrupt line is held by a two-state machine, IRQ_IDLE and IRQ_RAISED. From IRQ_IDLE the transition "raise" is taken when any enabled status bit is set; from IRQ_RAISED the transition "drop" is taken when none is. Each state otherwise holds.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: While reset is held, the status register and the mask read 0, both threshold registers read 1, and `irq` is 0.
- R2: Status bit 1 is 1 exactly when `rx_count` sampled at the previous clock edge was greater than or equal to the receive threshold then in force.
- R3: Status bit 3 is 1 exactly when `tx_count` sampled at the previous clock edge was strictly less than the transmit threshold then in force.
- R4: Status bits 2, 4 and 5 equal `rx_full`, `tx_full` and `tx_empty` sampled at the previous clock edge.
- R5: Status bit 0 is set when `rx_push` and `rx_full` are both 1 at a clock edge; it stays set, even after `rx_full` drops, until cleared by software.
- R6: A 1 on `ext_evt[i]` at a clock edge sets status bit 6+i, which then stays set until cleared by software.
- R7: A write to address 0 clears every event bit (0 and 6 to 12) whose data bit is 1; level bits (1 to 5) are unaffected by it; an event arriving in the same cycle as its clear leaves the bit set.
- R8: A write to address 1 sets the mask bits whose data bit is 1, a write to address 2 clears them, other mask bits keep their value, and reads of addresses 1, 2 and 3 return the mask.
- R9: `irq` is 1 in the cycle after one in which status AND mask is non-zero, and 0 in the cycle after one in which it is zero.
- R10: Addresses 4 and 5 hold the receive and transmit thresholds (low bits of the write data); status and mask reads carry zeros above bit 12, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | 5 | Receive FIFO occupancy |
| tx_count | input | 5 | Transmit FIFO occupancy |
| rx_full | input | 1 | Receive FIFO full flag |
| tx_full | input | 1 | Transmit FIFO full flag |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| rx_push | input | 1 | Pulse: a received word is offered to the receive FIFO |
| ext_evt | input | 7 | Pulses for the other sticky event sources |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches, on every cycle, that the threshold comparisons and the flag bits track the FIFO inputs one edge later, that the overflow bit latches and holds until a clearing write, that mask set and clear writes take effect on the named bits, and that the interrupt line follows the masked status one cycle behind. Reset values, the read-back of every address, the zero upper read bits, the priority of a new event over a simultaneous clear, the refusal of level bits to be cleared, and the external event positions are only shown by the bench's directed scenarios, which read the registers back through the port.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    // Fixed status bit positions; external events follow from FIXED_BITS up.
    localparam int B_RX_OVF   = 0;
    localparam int B_RX_LVL   = 1;
    localparam int B_RX_FULL  = 2;
    localparam int B_TX_LOW   = 3;
    localparam int B_TX_FULL  = 4;
    localparam int B_TX_EMPTY = 5;
    localparam int FIXED_BITS = 6;

    typedef enum logic [2:0] {
        A_STATUS    = 3'd0,
        A_MASK_SET  = 3'd1,
        A_MASK_CLR  = 3'd2,
        A_MASK_VIEW = 3'd3,
        A_RX_THR    = 3'd4,
        A_TX_THR    = 3'd5
    } reg_addr_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/spi_irq_level_eval.sv
module spi_irq_level_eval
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int ST_W  = 13
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_thr,
    input  logic [CNT_W-1:0] tx_thr,
    input  logic             rx_full,
    input  logic             tx_full,
    input  logic             tx_empty,
    output logic [ST_W-1:0]  lvl
);

    always_comb begin
        lvl             = '0;
        lvl[B_RX_LVL]   = (rx_count >= rx_thr);
        lvl[B_RX_FULL]  = rx_full;
        lvl[B_TX_LOW]   = (tx_count < tx_thr);
        lvl[B_TX_FULL]  = tx_full;
        lvl[B_TX_EMPTY] = tx_empty;
    end

endmodule

// File: rtl/spi_irq_status_reg.sv
module spi_irq_status_reg
    import spi_irq_pkg::*;
#(
    parameter int NUM_EXT_EVT = 7,
    parameter int ST_W        = FIXED_BITS + NUM_EXT_EVT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ST_W-1:0]        lvl,
    input  logic                   rx_push,
    input  logic                   rx_full,
    input  logic [NUM_EXT_EVT-1:0] ext_evt,
    input  logic [ST_W-1:0]        clr,
    output logic [ST_W-1:0]        status_q
);

    localparam logic [ST_W-1:0] LVL_MASK = ST_W'((1 << B_RX_LVL) | (1 << B_RX_FULL) |
                                                 (1 << B_TX_LOW) | (1 << B_TX_FULL) |
                                                 (1 << B_TX_EMPTY));

    logic [ST_W-1:0] evt_set;
    logic [ST_W-1:0] status_d;

    assign evt_set[B_RX_OVF]           = rx_push & rx_full;
    assign evt_set[FIXED_BITS-1:1]     = '0;

    for (genvar g = 0; g < NUM_EXT_EVT; g++) begin : g_ext
        assign evt_set[FIXED_BITS+g] = ext_evt[g];
    end

    // Level bits rebuilt each cycle; event bits held, cleared by W1C,
    // and a new event in the clearing cycle wins.
    always_comb begin
        status_d = (lvl & LVL_MASK) | (status_q & ~LVL_MASK & ~clr) | evt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

endmodule

// File: rtl/spi_irq_cfg_regs.sv
module spi_irq_cfg_regs
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int ST_W  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [ST_W-1:0]  wdata_st,
    input  logic [CNT_W-1:0] wdata_cnt,
    output logic [ST_W-1:0]  mask_q,
    output logic [CNT_W-1:0] rx_thr_q,
    output logic [CNT_W-1:0] tx_thr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            rx_thr_q <= CNT_W'(1);
            tx_thr_q <= CNT_W'(1);
        end else if (reg_wr) begin
            case (reg_addr)
                A_MASK_SET: mask_q   <= mask_q | wdata_st;
                A_MASK_CLR: mask_q   <= mask_q & ~wdata_st;
                A_RX_THR:   rx_thr_q <= wdata_cnt;
                A_TX_THR:   tx_thr_q <= wdata_cnt;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/spi_irq_line_fsm.sv
module spi_irq_line_fsm
    import spi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pending) state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int NUM_EXT_EVT = 7,
    parameter int DATA_W      = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(DEPTH+1)-1:0]    rx_count,
    input  logic [$clog2(DEPTH+1)-1:0]    tx_count,
    input  logic                          rx_full,
    input  logic                          tx_full,
    input  logic                          tx_empty,
    input  logic                          rx_push,
    input  logic [NUM_EXT_EVT-1:0]        ext_evt,
    input  logic                          reg_wr,
    input  logic [2:0]                    reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic                          irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int ST_W  = FIXED_BITS + NUM_EXT_EVT;

    logic [ST_W-1:0]  lvl;
    logic [ST_W-1:0]  status_q;
    logic [ST_W-1:0]  mask_q;
    logic [ST_W-1:0]  clr;
    logic [CNT_W-1:0] rx_thr_q;
    logic [CNT_W-1:0] tx_thr_q;
    logic             pending;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:ST_W];
    assign clr          = (reg_wr && reg_addr == A_STATUS) ? reg_wdata[ST_W-1:0] : '0;
    assign pending      = |(status_q & mask_q);

    spi_irq_level_eval #(.CNT_W(CNT_W), .ST_W(ST_W)) u_lvl (
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_thr   (rx_thr_q),
        .tx_thr   (tx_thr_q),
        .rx_full  (rx_full),
        .tx_full  (tx_full),
        .tx_empty (tx_empty),
        .lvl      (lvl)
    );

    spi_irq_status_reg #(.NUM_EXT_EVT(NUM_EXT_EVT), .ST_W(ST_W)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl),
        .rx_push  (rx_push),
        .rx_full  (rx_full),
        .ext_evt  (ext_evt),
        .clr      (clr),
        .status_q (status_q)
    );

    spi_irq_cfg_regs #(.CNT_W(CNT_W), .ST_W(ST_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .wdata_st  (reg_wdata[ST_W-1:0]),
        .wdata_cnt (reg_wdata[CNT_W-1:0]),
        .mask_q    (mask_q),
        .rx_thr_q  (rx_thr_q),
        .tx_thr_q  (tx_thr_q)
    );

    spi_irq_line_fsm u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STATUS:    reg_rdata[ST_W-1:0]  = status_q;
            A_MASK_SET,
            A_MASK_CLR,
            A_MASK_VIEW: reg_rdata[ST_W-1:0]  = mask_q;
            A_RX_THR:    reg_rdata[CNT_W-1:0] = rx_thr_q;
            A_TX_THR:    reg_rdata[CNT_W-1:0] = tx_thr_q;
            default:     reg_rdata            = '0;
        endcase
    end

endmodule

// File: rtl/spi_fifo_irq_ctrl_chk.sv
module spi_fifo_irq_ctrl_chk #(
    parameter int CNT_W = 5,
    parameter int ST_W  = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic             rx_full,
    input logic             tx_full,
    input logic             tx_empty,
    input logic             rx_push,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [ST_W-1:0]  wdata_st,
    input logic [ST_W-1:0]  status_q,
    input logic [ST_W-1:0]  mask_q,
    input logic [CNT_W-1:0] rx_thr_q,
    input logic [CNT_W-1:0] tx_thr_q,
    input logic             irq
);

    // R2
    rx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> status_q[1] == ($past(rx_count) >= $past(rx_thr_q)));

    // R3
    tx_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> status_q[3] == ($past(tx_count) < $past(tx_thr_q)));

    // R4
    fifo_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (status_q[2] == $past(rx_full)) && (status_q[4] == $past(tx_full))
                  && (status_q[5] == $past(tx_empty)));

    // R5
    rx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> status_q[0]);

    // R5
    rx_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[0] && !(reg_wr && reg_addr == 3'd0 && wdata_st[0])) |=> status_q[0]);

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1) |=> ((mask_q & $past(wdata_st)) == $past(wdata_st)));

    // R8
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd2) |=> ((mask_q & $past(wdata_st)) == '0));

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> irq == (|($past(status_q) & $past(mask_q))));

endmodule

bind spi_fifo_irq_ctrl spi_fifo_irq_ctrl_chk #(.CNT_W(CNT_W), .ST_W(ST_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_count (rx_count),
    .tx_count (tx_count),
    .rx_full  (rx_full),
    .tx_full  (tx_full),
    .tx_empty (tx_empty),
    .rx_push  (rx_push),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wdata_st (reg_wdata[ST_W-1:0]),
    .status_q (status_q),
    .mask_q   (mask_q),
    .rx_thr_q (rx_thr_q),
    .tx_thr_q (tx_thr_q),
    .irq      (irq)
);

// File: tb/sim_spi_fifo_irq_ctrl.sv
`timescale 1ns/1ps
module sim_spi_fifo_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rx_count = '0;
    logic [4:0]  tx_count = '0;
    logic        rx_full = 1'b0;
    logic        tx_full = 1'b0;
    logic        tx_empty = 1'b1;
    logic        rx_push = 1'b0;
    logic [6:0]  ext_evt = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    spi_fifo_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .rx_full(rx_full), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_push(rx_push), .ext_evt(ext_evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        repeat (3) tick();
        rd(3'd0, v); chk("R1 status", v, 32'h0);
        rd(3'd3, v); chk("R1 mask", v, 32'h0);
        rd(3'd4, v); chk("R1 rx_thr", v, 32'h1);
        rd(3'd5, v); chk("R1 tx_thr", v, 32'h1);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        tick();
        rd(3'd0, v); chk("R3/R4 idle status", v, 32'h28);
    endtask

    task automatic t_thresholds();
        logic [31:0] v;
        wr(3'd4, 32'd4);
        wr(3'd5, 32'd2);
        rd(3'd4, v); chk("R10 rx_thr readback", v, 32'd4);
        rd(3'd5, v); chk("R10 tx_thr readback", v, 32'd2);
        tx_empty = 1'b0; rx_count = 5'd3; tx_count = 5'd1;
        tick(); rd(3'd0, v); chk("R2/R3 below rx thr", v, 32'h08);
        rx_count = 5'd4; tx_count = 5'd2;
        tick(); rd(3'd0, v); chk("R2/R3 at thr", v, 32'h02);
        rx_count = 5'd16;
        tick(); rd(3'd0, v); chk("R2 above rx thr", v, 32'h02);
        wr(3'd4, 32'd0);
        rx_count = 5'd0; tx_count = 5'd0;
        tick(); rd(3'd0, v); chk("R2 zero thr", v, 32'h0A);
        wr(3'd4, 32'd1);
        wr(3'd5, 32'd1);
    endtask

    task automatic t_flags();
        logic [31:0] v;
        rx_count = 5'd0; tx_count = 5'd5;
        rx_full = 1'b1; tx_full = 1'b1; tx_empty = 1'b0;
        tick(); rd(3'd0, v); chk("R4 full flags", v, 32'h14);
        rx_full = 1'b0; tx_full = 1'b0; tx_empty = 1'b1;
        tick(); rd(3'd0, v); chk("R4 tx empty", v, 32'h20);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        rx_push = 1'b1;
        tick(); rx_push = 1'b0;
        rd(3'd0, v); chk("R5 push not full", v, 32'h20);
        rx_full = 1'b1; rx_push = 1'b1;
        tick(); rx_push = 1'b0;
        rd(3'd0, v); chk("R5 overflow set", v, 32'h25);
        rx_full = 1'b0;
        tick(); rd(3'd0, v); chk("R5 overflow sticky", v, 32'h21);
        wr(3'd0, 32'h3E);
        rd(3'd0, v); chk("R7 level bits not cleared", v, 32'h21);
        wr(3'd0, 32'h01);
        rd(3'd0, v); chk("R7 overflow cleared", v, 32'h20);
    endtask

    task automatic t_ext();
        logic [31:0] v;
        ext_evt = 7'b0001000;
        tick(); ext_evt = '0;
        rd(3'd0, v); chk("R6 ext event bit9", v, 32'h220);
        tick(); rd(3'd0, v); chk("R6 ext event sticky", v, 32'h220);
        wr(3'd0, 32'h200);
        rd(3'd0, v); chk("R7 ext event cleared", v, 32'h20);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        rx_full = 1'b1; rx_push = 1'b1;
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h01;
        tick();
        reg_wr = 1'b0; reg_wdata = '0; rx_push = 1'b0; rx_full = 1'b0;
        rd(3'd0, v); chk("R7 set wins over clear", v, 32'h25);
        wr(3'd0, 32'h01);
        rd(3'd0, v); chk("R7 clear after set", v, 32'h20);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(3'd1, 32'h22);
        rd(3'd3, v); chk("R8 mask set", v, 32'h22);
        chk("R9 irq latency low", {31'b0, irq}, 32'h0);
        tick(); chk("R9 irq raised", {31'b0, irq}, 32'h1);
        wr(3'd2, 32'h20);
        chk("R9 irq still high", {31'b0, irq}, 32'h1);
        rd(3'd1, v); chk("R8 mask clr via addr1 read", v, 32'h02);
        rd(3'd2, v); chk("R8 mask via addr2 read", v, 32'h02);
        tick(); chk("R9 irq dropped", {31'b0, irq}, 32'h0);
        wr(3'd1, 32'h0);
        rd(3'd3, v); chk("R8 zero set no change", v, 32'h02);
    endtask

    task automatic t_width();
        logic [31:0] v;
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R10 status upper zero", v, 32'h20);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd3, v); chk("R10 mask 13 bits", v, 32'h1FFF);
        tick(); chk("R9 irq all enabled", {31'b0, irq}, 32'h1);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd3, v); chk("R8 mask all cleared", v, 32'h0);
        rd(3'd6, v); chk("R10 addr6 zero", v, 32'h0);
        rd(3'd7, v); chk("R10 addr7 zero", v, 32'h0);
    endtask

    initial begin
        t_reset();
        t_thresholds();
        t_flags();
        t_overflow();
        t_ext();
        t_set_wins();
        t_mask();
        t_width();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule